// File: doc/BRIEF.md
# Sample Interleaver and Code Formatter

This block takes the stream of codes coming out of a sampling converter core, one code per conversion-clock edge. It sends them to two output ports. First, a polarity stage registers each incoming code. The stage either passes the code unchanged or complements every bit of it.

Split mode is selected when `mode_split` is high. A divide-by-two phase counter steers alternate samples to port 1 and port 2. Both ports update together once every two conversion cycles. `clk_out` is the half-rate clock, and its rising edge falls midway through each two-cycle data window. The phase counter can be forced to a known state through `div_align_n`, so that several parallel units start their pairs in step.

Straight mode is selected when `mode_split` is low. Every code goes to port 1 at the full rate, and `clk_out` is the inverted conversion clock.

Top module: `sample_interleaver`

## Requirements
- R1: While `rst_n` is low, both ports read zero and, with `mode_split` high, `clk_out` reads low.
- R2: In split mode, counting from the first edge after reset or after an alignment edge, even-numbered samples go to port 1 and odd-numbered samples go to port 2. The pair (sample 2k, sample 2k+1) appears on both ports together right after the edge that captures sample 2k+2.
- R3: In split mode, the ports change only on every second conversion edge. They hold their values across the edge in between.
- R4: In split mode, `clk_out` falls on the edge where the ports update and rises one conversion cycle later, giving half the conversion rate.
- R5: An edge with `div_align_n` low makes the sample captured on that edge the port 2 half of the current pair. The first sample after release then goes to port 1 and the next to port 2.
- R6: In straight mode, port 1 shows each sample right after the edge following its capture, which is two edges of latency. Port 2 holds its last value.
- R7: In straight mode, `clk_out` is the complement of `clk`: high while `clk` is low, low while `clk` is high.
- R8: With `pol_true` high a code passes unchanged, so full scale gives 0xFF and zero gives 0x00. With `pol_true` low every bit is complemented. The polarity is applied when the sample is captured, so a change affects only later samples.
- R9: When `mode_split` goes from low to high, the first sample captured with it high goes to port 1 and its successor to port 2, with no alignment pulse needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_in | input | CODE_W | Sample code from the converter core |
| pol_true | input | 1 | High: pass codes unchanged; low: complement codes |
| mode_split | input | 1 | High: two-port split mode; low: straight mode |
| div_align_n | input | 1 | Synchronous active-low divider phase alignment |
| port1_data | output | CODE_W | First output port (older sample of each pair) |
| port2_data | output | CODE_W | Second output port (newer sample of each pair) |
| clk_out | output | 1 | Half-rate pair clock in split mode, inverted clk in straight mode |

## Verification
The bench builds the block with its default 8-bit code width. With that width, a short ramp crosses both full-scale boundaries: it wraps from 0xFF to 0x00 in both polarity settings, so the inversion of the extreme codes is reached within a few samples. The same width keeps the expected code table small enough to track every captured sample. Each pair position, the alignment pulse, and both mode transitions can then be checked sample by sample.

// File: rtl/si_pkg.sv
package si_pkg;

    // Which output port the sample held in the polarity stage belongs to.
    typedef enum logic {
        LANE_FIRST  = 1'b0,
        LANE_SECOND = 1'b1
    } lane_e;

    localparam int DEF_CODE_W = 8;

endpackage

// File: rtl/code_shaper.sv
module code_shaper #(
    parameter int CODE_W = si_pkg::DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] raw_code,
    input  logic              pol_true,
    output logic [CODE_W-1:0] code_q
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
    } shaper_t;

    localparam logic [CODE_W-1:0] ALL_ONES = '1;

    shaper_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Complement is an XOR with all ones when the true polarity is off.
        st_d.code = pol_true ? raw_code : (raw_code ^ ALL_ONES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_q = st_q.code;

endmodule

// File: rtl/lane_phase.sv
module lane_phase (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          split,
    input  logic          align_n,
    output si_pkg::lane_e lane_q,
    output logic          div_clk_q
);
    import si_pkg::*;

    typedef struct packed {
        lane_e lane;
        logic  div_clk;
    } phase_t;

    phase_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        // Half-rate clock is high in the cycle after a first-lane capture.
        ph_d.div_clk = (ph_q.lane == LANE_FIRST);
        if (!align_n || !split) begin
            // Park on the second lane so the next split sample opens a pair.
            ph_d.lane = LANE_SECOND;
        end else if (ph_q.lane == LANE_FIRST) begin
            ph_d.lane = LANE_SECOND;
        end else begin
            ph_d.lane = LANE_FIRST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q.lane    <= LANE_SECOND;
            ph_q.div_clk <= 1'b0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign lane_q    = ph_q.lane;
    assign div_clk_q = ph_q.div_clk;

endmodule

// File: rtl/lane_router.sv
module lane_router #(
    parameter int CODE_W = si_pkg::DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              split,
    input  si_pkg::lane_e     lane,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] port1_q,
    output logic [CODE_W-1:0] port2_q
);
    import si_pkg::*;

    typedef struct packed {
        logic [CODE_W-1:0] hold;
        logic [CODE_W-1:0] p1;
        logic [CODE_W-1:0] p2;
    } route_t;

    route_t rt_d, rt_q;

    always_comb begin
        rt_d = rt_q;
        if (split) begin
            if (lane == LANE_FIRST) begin
                // Park the older sample until its partner arrives.
                rt_d.hold = code;
            end else begin
                rt_d.p1 = rt_q.hold;
                rt_d.p2 = code;
            end
        end else begin
            rt_d.p1 = code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rt_q <= '0;
        end else begin
            rt_q <= rt_d;
        end
    end

    assign port1_q = rt_q.p1;
    assign port2_q = rt_q.p2;

endmodule

// File: rtl/sample_interleaver.sv
module sample_interleaver #(
    parameter int CODE_W = si_pkg::DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              pol_true,
    input  logic              mode_split,
    input  logic              div_align_n,
    output logic [CODE_W-1:0] port1_data,
    output logic [CODE_W-1:0] port2_data,
    output logic              clk_out
);
    import si_pkg::*;

    logic [CODE_W-1:0] shaped;
    lane_e             lane_sel;
    logic              div_clk;

    code_shaper #(.CODE_W(CODE_W)) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_code (code_in),
        .pol_true (pol_true),
        .code_q   (shaped)
    );

    lane_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .split     (mode_split),
        .align_n   (div_align_n),
        .lane_q    (lane_sel),
        .div_clk_q (div_clk)
    );

    lane_router #(.CODE_W(CODE_W)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .split   (mode_split),
        .lane    (lane_sel),
        .code    (shaped),
        .port1_q (port1_data),
        .port2_q (port2_data)
    );

    // Straight mode forwards the inverted conversion clock.
    assign clk_out = mode_split ? div_clk : ~clk;

endmodule

// File: rtl/sample_interleaver_chk.sv
module sample_interleaver_chk #(
    parameter int CODE_W = si_pkg::DEF_CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code_in,
    input logic              pol_true,
    input logic              mode_split,
    input logic              div_align_n,
    input logic [CODE_W-1:0] port1_data,
    input logic [CODE_W-1:0] port2_data,
    input logic              clk_out,
    input si_pkg::lane_e     lane_sel,
    input logic              div_clk
);
    import si_pkg::*;

    logic [1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= 2'd0;
        end else if (seen != 2'd3) begin
            seen <= seen + 2'd1;
        end
    end

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |-> (port1_data == '0 && port2_data == '0));

    // R3
    a_r3_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_split && lane_sel == LANE_FIRST) |=> ($stable(port1_data) && $stable(port2_data)));

    // R4
    a_r4_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_split && div_align_n) |=> (div_clk == (lane_sel == LANE_SECOND)));

    // R5
    a_r5_align_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !div_align_n |=> (lane_sel == LANE_SECOND));

    // R6 and R8: port 1 follows the formatted sample two edges later
    a_r6_straight_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && $past(!mode_split))
        |-> (port1_data == $past(pol_true ? code_in : ~code_in, 2)));

    // R6
    a_r6_port2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_split |=> $stable(port2_data));

    // R7
    always @(negedge clk) begin
        if (rst_n && !mode_split) begin
            a_r7_inverted_clock: assert (clk_out == 1'b1);
        end
    end

endmodule

bind sample_interleaver sample_interleaver_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .code_in     (code_in),
    .pol_true    (pol_true),
    .mode_split  (mode_split),
    .div_align_n (div_align_n),
    .port1_data  (port1_data),
    .port2_data  (port2_data),
    .clk_out     (clk_out),
    .lane_sel    (lane_sel),
    .div_clk     (div_clk)
);

// File: tb/sample_interleaver_test.sv
module sample_interleaver_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic [W-1:0] code_in = '0;
    logic         pol_true = 1'b1;
    logic         mode_split = 1'b1;
    logic         div_align_n = 1'b1;
    logic [W-1:0] port1_data, port2_data;
    logic         clk_out;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] fexp [0:63];
    int n = 0;

    always #4 clk = ~clk;

    sample_interleaver #(.CODE_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .code_in(code_in), .pol_true(pol_true),
        .mode_split(mode_split), .div_align_n(div_align_n),
        .port1_data(port1_data), .port2_data(port2_data), .clk_out(clk_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply one code, let the next edge capture it, land 1 ns after the edge.
    task automatic push(input logic [W-1:0] c);
        code_in = c;
        fexp[n] = pol_true ? c : ~c;
        n++;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic split);
        rst_n = 1'b0;
        mode_split = split;
        div_align_n = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R1 port1", port1_data, '0);
        check("R1 port2", port2_data, '0);
        if (split) check("R1 clk_out", {7'b0, clk_out}, 8'h00);
        rst_n = 1'b1;
        n = 0;
    endtask

    task automatic t_split(input logic pol);
        do_reset(1'b1);
        pol_true = pol;
        for (int i = 0; i < 16; i++) begin
            int idx;
            push(8'hF8 + 8'(i));
            idx = n - 1;
            if (idx >= 2 && idx % 2 == 0) begin
                check("R2/R8 port1", port1_data, fexp[idx-2]);
                check("R2/R8 port2", port2_data, fexp[idx-1]);
                check("R4 clk_out low", {7'b0, clk_out}, 8'h00);
            end else if (idx >= 3) begin
                check("R3 port1 hold", port1_data, fexp[idx-3]);
                check("R3 port2 hold", port2_data, fexp[idx-2]);
                check("R4 clk_out high", {7'b0, clk_out}, 8'h01);
            end
        end
        pol_true = 1'b1;
    endtask

    task automatic t_align;
        do_reset(1'b1);
        push(8'h40);
        push(8'h41);
        div_align_n = 1'b0;
        push(8'h42);
        div_align_n = 1'b1;
        check("R5 pair before align p1", port1_data, fexp[0]);
        check("R5 pair before align p2", port2_data, fexp[1]);
        push(8'h43);
        check("R5 aligned sample on port2", port2_data, fexp[2]);
        check("R5 clk_out low", {7'b0, clk_out}, 8'h00);
        push(8'h44);
        check("R5 clk_out high", {7'b0, clk_out}, 8'h01);
        check("R5 port2 held", port2_data, fexp[2]);
        push(8'h45);
        check("R5 first after release on port1", port1_data, fexp[3]);
        check("R5 second after release on port2", port2_data, fexp[4]);
        check("R5 clk_out low again", {7'b0, clk_out}, 8'h00);
    endtask

    task automatic t_straight(input logic pol);
        do_reset(1'b0);
        pol_true = pol;
        for (int i = 0; i < 10; i++) begin
            int idx;
            push(8'hFC + 8'(i));
            idx = n - 1;
            if (idx >= 1) begin
                check("R6/R8 port1", port1_data, fexp[idx-1]);
                check("R6 port2 hold", port2_data, '0);
            end
            check("R7 clk_out while clk high", {7'b0, clk_out}, 8'h00);
            @(negedge clk);
            check("R7 clk_out while clk low", {7'b0, clk_out}, 8'h01);
        end
        pol_true = 1'b1;
    endtask

    task automatic t_pol_toggle;
        do_reset(1'b0);
        for (int i = 0; i < 8; i++) begin
            int idx;
            pol_true = i[0];
            push(8'h3C + 8'(i));
            idx = n - 1;
            if (idx >= 1) check("R8 per-sample polarity", port1_data, fexp[idx-1]);
        end
        pol_true = 1'b1;
    endtask

    task automatic t_switch;
        do_reset(1'b1);
        for (int i = 0; i < 8; i++) push(8'h80 + 8'(i));
        check("R2 last pair port2", port2_data, fexp[5]);
        mode_split = 1'b0;
        for (int i = 0; i < 4; i++) begin
            push(8'h90 + 8'(i));
            check("R6 port1 after switch", port1_data, fexp[n-2]);
            check("R6 port2 holds split value", port2_data, fexp[5]);
        end
        mode_split = 1'b1;
        push(8'hA0);
        push(8'hA1);
        push(8'hA2);
        check("R9 first split sample on port1", port1_data, fexp[12]);
        check("R9 second split sample on port2", port2_data, fexp[13]);
    endtask

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1 rst_n = 1'b0;
        t_split(1'b1);
        t_split(1'b0);
        t_align();
        t_straight(1'b1);
        t_straight(1'b0);
        t_pol_toggle();
        t_switch();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule